// File: doc/BRIEF.md
# Clock-Correction Failure Error-Level Tracker

This block watches whether a time-triggered bus controller manages to apply clock rate correction. Rate correction needs a measurement over two communication cycles, so the block makes one decision per double cycle, at the end of every odd cycle. Each double cycle that lacks the sync frame pairs needed for correction increments a saturating failure counter. A double cycle with good correction clears that counter.

The counter is compared against two host-programmed 15-bit limits. Reaching the passive limit moves the node from green to yellow. Reaching the fatal limit moves it to red, and red asks the node to stop communicating. Each upward step pulses an interrupt and sets a status bit, which the host clears by writing 1 to it. The limits can be changed only while the controller is in its configuration state. Escalation stays disabled until both limits hold non-zero values.

Top module: `cc_err_level_tracker`

## Requirements
- R1: After reset the level is green (2'b00) and `halt_o` is low. The failure count is 0, `irq_o` and `irq_flag_o` are low, and both limits read back as 0.
- R2: A write to address 0xCC loads the fatal limit and a write to 0xD8 loads the passive limit, each from `wr_data_i[14:0]`. Both limits read back on `rd_data_o` with bit 15 at 0. A write that arrives while `cfg_mode_i` is low changes neither limit.
- R3: An update happens on a clock with `cyc_end_i` high, `cyc_odd_i` high and `cfg_mode_i` low. When `sync_miss_i` is high the count rises by one. A cycle end with `cyc_odd_i` low changes nothing. The count stops at 32767 and does not wrap.
- R4: An update with `sync_miss_i` low sets the count to 0. If the level is yellow, that update also returns it to green.
- R5: An update after which the count is at or above the passive limit, but below the fatal limit, moves green to yellow (2'b01). It also pulses `irq_o` high for exactly one clock.
- R6: An update after which the count is at or above the fatal limit sets the level to red (2'b10), drives `halt_o` high and pulses `irq_o`. If both limits are reached in the same update, red wins.
- R7: Red is kept through all later updates, good ones included, until `cfg_mode_i` is high. While `cfg_mode_i` is high the level is forced to green and the count to 0.
- R8: Each `irq_o` pulse sets `irq_flag_o`, which also reads as bit 0 at address 0xE0. A write to 0xE0 with data bit 0 set clears the flag in any state. A new pulse in the same clock as that write wins over the clear.
- R9: While either limit is 0, updates still count, but the level never leaves green and no interrupt is raised.
- R10: The level is never 2'b11. `level_o` and `fail_cnt_o` change on the clock edge that samples the update, so they are valid one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 1 | Controller is in configuration state |
| cyc_end_i | input | 1 | Single-clock strobe at the end of a communication cycle |
| cyc_odd_i | input | 1 | The ending cycle is odd-numbered |
| sync_miss_i | input | 1 | Sync frame pairs for rate correction were missing in this double cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 16 | Read data for `rd_addr_i`, combinational |
| level_o | output | 2 | Error level: 00 green, 01 yellow, 10 red |
| halt_o | output | 1 | Level is red; communication must stop |
| irq_o | output | 1 | One-clock pulse on every upward level change |
| irq_flag_o | output | 1 | Latched interrupt status |
| fail_cnt_o | output | 15 | Current failure count |

## Verification
Directed sequences run the escalation ladder with a passive limit of 2 and a fatal limit of 4. They separate counting on odd cycles from counting on even cycles, and the drop from yellow to green from the hold on red. One run sets both limits to 32767. It shows that red wins over yellow when both limits are reached together, and that the count stops at its maximum instead of wrapping. Random rounds draw small limits, including equal and inverted pairs, and mix odd and even cycle ends with missing and present sync pairs. This shows whether resets of the counter and the level interact correctly with escalation. Writes outside the configuration state, and updates while both limits are zero, check that locked or unarmed limits have no effect.

// File: rtl/cc_err_pkg.sv
package cc_err_pkg;
  typedef enum logic [1:0] {
    LVL_GREEN  = 2'b00,
    LVL_YELLOW = 2'b01,
    LVL_RED    = 2'b10
  } err_lvl_e;

  localparam logic [7:0] ADDR_FATAL   = 8'hCC;
  localparam logic [7:0] ADDR_PASSIVE = 8'hD8;
  localparam logic [7:0] ADDR_STATUS  = 8'hE0;
endpackage

// File: rtl/cc_thr_regs.sv
module cc_thr_regs #(
  parameter int          CNT_W        = 15,
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 16,
  parameter logic [ADDR_W-1:0] FATAL_ADDR = 8'hCC,
  parameter logic [ADDR_W-1:0] PASS_ADDR  = 8'hD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  thr_fatal_o,
  output logic [CNT_W-1:0]  thr_pass_o,
  output logic              armed_o
);
  logic [CNT_W-1:0] fatal_q, fatal_d;
  logic [CNT_W-1:0] pass_q,  pass_d;
  logic             fatal_we, pass_we;

  always_comb begin
    fatal_we = wr_en_i && cfg_mode_i && (wr_addr_i == FATAL_ADDR);
    pass_we  = wr_en_i && cfg_mode_i && (wr_addr_i == PASS_ADDR);
    fatal_d  = fatal_we ? wr_data_i[CNT_W-1:0] : fatal_q;
    pass_d   = pass_we  ? wr_data_i[CNT_W-1:0] : pass_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_q <= '0;
      pass_q  <= '0;
    end else begin
      if (fatal_we) fatal_q <= fatal_d;
      if (pass_we)  pass_q  <= pass_d;
    end
  end

  assign thr_fatal_o = fatal_q;
  assign thr_pass_o  = pass_q;
  assign armed_o     = (fatal_q != '0) && (pass_q != '0);
endmodule

// File: rtl/cc_fail_counter.sv
module cc_fail_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             miss_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || upd_i;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (upd_i) begin
      if (!miss_i)              cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
endmodule

// File: rtl/cc_level_fsm.sv
module cc_level_fsm
  import cc_err_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_i,
  input  logic             upd_i,
  input  logic             miss_i,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] thr_fatal_i,
  input  logic [CNT_W-1:0] thr_pass_i,
  output err_lvl_e         lvl_o,
  output logic             up_evt_o,
  output logic             irq_o
);
  err_lvl_e lvl_q, lvl_d;
  logic     irq_q;
  logic     hit_fatal, hit_pass;

  always_comb begin
    hit_fatal = armed_i && miss_i && (cnt_nxt_i >= thr_fatal_i);
    hit_pass  = armed_i && miss_i && (cnt_nxt_i >= thr_pass_i);
    lvl_d     = lvl_q;
    if (cfg_i) begin
      lvl_d = LVL_GREEN;
    end else if (upd_i && (lvl_q != LVL_RED)) begin
      if (hit_fatal)    lvl_d = LVL_RED;
      else if (hit_pass) lvl_d = LVL_YELLOW;
      else if (!miss_i) lvl_d = LVL_GREEN;
    end
    up_evt_o = (lvl_d > lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_GREEN;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      irq_q <= up_evt_o;
    end
  end

  assign lvl_o = lvl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/cc_err_level_tracker.sv
module cc_err_level_tracker
  import cc_err_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode_i,
  input  logic              cyc_end_i,
  input  logic              cyc_odd_i,
  input  logic              sync_miss_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        level_o,
  output logic              halt_o,
  output logic              irq_o,
  output logic              irq_flag_o,
  output logic [CNT_W-1:0]  fail_cnt_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] thr_fatal_w, thr_pass_w, cnt_nxt_w;
  logic             armed_w, upd_w, up_evt_w;
  logic             flag_q, flag_d, flag_clr;
  err_lvl_e         lvl_w;

  assign upd_w = cyc_end_i && cyc_odd_i && !cfg_mode_i;

  cc_thr_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FATAL_ADDR(ADDR_FATAL), .PASS_ADDR(ADDR_PASSIVE)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .thr_fatal_o(thr_fatal_w), .thr_pass_o(thr_pass_w), .armed_o(armed_w)
  );

  cc_fail_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cfg_mode_i), .upd_i(upd_w),
    .miss_i(sync_miss_i), .cnt_o(fail_cnt_o), .cnt_nxt_o(cnt_nxt_w)
  );

  cc_level_fsm #(.CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_mode_i), .upd_i(upd_w),
    .miss_i(sync_miss_i), .armed_i(armed_w), .cnt_nxt_i(cnt_nxt_w),
    .thr_fatal_i(thr_fatal_w), .thr_pass_i(thr_pass_w),
    .lvl_o(lvl_w), .up_evt_o(up_evt_w), .irq_o(irq_o)
  );

  always_comb begin
    flag_clr = wr_en_i && (wr_addr_i == ADDR_STATUS) && wr_data_i[0];
    flag_d   = up_evt_w || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_FATAL:   rd_data_o = {{PAD_W{1'b0}}, thr_fatal_w};
      ADDR_PASSIVE: rd_data_o = {{PAD_W{1'b0}}, thr_pass_w};
      ADDR_STATUS:  rd_data_o = {{(DATA_W-1){1'b0}}, flag_q};
      default:      rd_data_o = '0;
    endcase
  end

  assign level_o    = lvl_w;
  assign halt_o     = (lvl_w == LVL_RED);
  assign irq_flag_o = flag_q;
endmodule

// File: rtl/cc_err_level_chk.sv
module cc_err_level_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_mode_i,
  input logic             upd_w,
  input logic             sync_miss_i,
  input logic             armed_w,
  input logic [CNT_W-1:0] fail_cnt_o,
  input logic [1:0]       level_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] thr_fatal_w,
  input logic [CNT_W-1:0] thr_pass_w
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_thr_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode_i |=> ($stable(thr_fatal_w) && $stable(thr_pass_w)));

  p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_w && sync_miss_i && fail_cnt_o != CNT_MAX) |=> fail_cnt_o == $past(fail_cnt_o) + 1'b1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_w && sync_miss_i && fail_cnt_o == CNT_MAX) |=> fail_cnt_o == CNT_MAX);

  p_good_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_w && !sync_miss_i) |=> fail_cnt_o == '0);

  p_irq_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> level_o > $past(level_o));

  p_red_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 2'b10 && !cfg_mode_i) |=> level_o == 2'b10);

  p_cfg_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode_i |=> (level_o == 2'b00 && fail_cnt_o == '0));

  p_unarmed_green_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_w && level_o == 2'b00) |=> level_o == 2'b00);

  p_legal_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'b11);
endmodule

bind cc_err_level_tracker cc_err_level_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode_i), .upd_w(upd_w),
  .sync_miss_i(sync_miss_i), .armed_w(armed_w), .fail_cnt_o(fail_cnt_o),
  .level_o(level_o), .irq_o(irq_o), .thr_fatal_w(thr_fatal_w),
  .thr_pass_w(thr_pass_w)
);

// File: tb/cc_err_level_tracker_tb_top.sv
`timescale 1ns/1ps
module cc_err_level_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mode_i, cyc_end_i, cyc_odd_i, sync_miss_i, wr_en_i;
  logic [7:0]  wr_addr_i, rd_addr_i;
  logic [15:0] wr_data_i, rd_data_o;
  logic [1:0]  level_o;
  logic        halt_o, irq_o, irq_flag_o;
  logic [14:0] fail_cnt_o;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit done = 1'b0;

  int m_cnt, m_lvl, m_thrf, m_thrp;
  bit m_cfg, m_irq, m_flag;

  always #10 clk = ~clk;

  cc_err_level_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode_i), .cyc_end_i(cyc_end_i),
    .cyc_odd_i(cyc_odd_i), .sync_miss_i(sync_miss_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .level_o(level_o), .halt_o(halt_o), .irq_o(irq_o),
    .irq_flag_o(irq_flag_o), .fail_cnt_o(fail_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_lvl(int lvl, int cnt, bit miss);
    bit armed = (m_thrf != 0) && (m_thrp != 0);
    if (lvl == 2) return 2;
    if (miss && armed && cnt >= m_thrf) return 2;
    if (miss && armed && cnt >= m_thrp) return 1;
    if (!miss) return 0;
    return lvl;
  endfunction

  task automatic check_state(input string req);
    chk({req, " count"}, fail_cnt_o, m_cnt);
    chk({req, " level"}, level_o, m_lvl);
    chk({req, " halt"}, halt_o, (m_lvl == 2));
    chk({req, " irq"}, irq_o, m_irq);
    chk({req, " flag"}, irq_flag_o, m_flag);
  endtask

  task automatic cyc(input bit odd, input bit miss, input string req);
    int nl;
    @(negedge clk);
    cyc_end_i = 1'b1; cyc_odd_i = odd; sync_miss_i = miss;
    m_irq = 1'b0;
    if (!m_cfg && odd) begin
      if (miss) m_cnt = (m_cnt == 32767) ? m_cnt : m_cnt + 1;
      else      m_cnt = 0;
      nl = next_lvl(m_lvl, m_cnt, miss);
      m_irq = (nl > m_lvl);
      if (m_irq) m_flag = 1'b1;
      m_lvl = nl;
    end
    @(negedge clk);
    cyc_end_i = 1'b0;
    check_state(req);
    m_irq = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    if (m_cfg && a == 8'hCC) m_thrf = d[14:0];
    if (m_cfg && a == 8'hD8) m_thrp = d[14:0];
    if (a == 8'hE0 && d[0]) m_flag = 1'b0;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    rd_addr_i = a;
    #1;
    chk(req, rd_data_o, exp);
  endtask

  task automatic set_cfg(input bit c);
    @(negedge clk);
    cfg_mode_i = c; m_cfg = c;
    if (c) begin m_cnt = 0; m_lvl = 0; end
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 190000 && !done) begin
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=finish", cyc_cnt);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_mode_i = 1'b0; cyc_end_i = 1'b0; cyc_odd_i = 1'b0;
    sync_miss_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    rd_addr_i = '0;
    m_cnt = 0; m_lvl = 0; m_thrf = 0; m_thrp = 0; m_cfg = 0; m_irq = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");
    rd(8'hCC, 0, "R1 fatal limit after reset");
    rd(8'hD8, 0, "R1 passive limit after reset");

    wr(8'hCC, 16'd5);
    rd(8'hCC, 0, "R2 write outside configuration ignored");
    cyc(1, 1, "R9 unarmed counts");
    cyc(1, 1, "R9 unarmed stays green");
    cyc(1, 1, "R9 unarmed three");

    set_cfg(1);
    check_state("R7 configuration clears");
    cyc(1, 1, "R3 no update in configuration");
    wr(8'hCC, 16'hFFFF & 16'h8004);
    wr(8'hD8, 16'd2);
    rd(8'hCC, 4, "R2 fatal readback bit15 zero");
    rd(8'hD8, 2, "R2 passive readback");
    set_cfg(0);

    cyc(0, 1, "R3 even cycle ignored");
    cyc(1, 1, "R3 first miss");
    cyc(1, 1, "R5 yellow at passive");
    @(negedge clk);
    chk("R5 irq single pulse", irq_o, 0);
    rd(8'hE0, 1, "R8 status flag read");
    cyc(1, 0, "R4 good correction back to green");
    cyc(1, 1, "R3 miss one");
    cyc(1, 1, "R5 yellow again");
    cyc(1, 1, "R5 yellow holds");
    cyc(1, 1, "R6 red at fatal");
    cyc(1, 0, "R7 red sticky over good update");
    wr(8'hE0, 16'h0001);
    chk("R8 write one clears flag", irq_flag_o, 0);
    rd(8'hE0, 0, "R8 status after clear");
    set_cfg(1);
    check_state("R7 configuration leaves red");

    wr(8'hCC, 16'd32767);
    wr(8'hD8, 16'd32767);
    set_cfg(0);
    for (int i = 0; i < 32766; i++) cyc(1, 1, "R3 long run");
    cyc(1, 1, "R6 red wins when both reached");
    cyc(1, 1, "R3 saturates at max");
    wr(8'hE0, 16'h0001);

    for (int r = 0; r < 6; r++) begin
      set_cfg(1);
      wr(8'hCC, 16'($urandom_range(1, 6)));
      wr(8'hD8, 16'($urandom_range(1, 6)));
      set_cfg(0);
      for (int k = 0; k < 150; k++) begin
        bit o = ($urandom_range(0, 3) != 0);
        bit m = ($urandom_range(0, 2) != 0);
        if (k % 37 == 36) begin
          set_cfg(1);
          set_cfg(0);
        end
        if (k % 23 == 22) wr(8'hE0, 16'h0001);
        if (k % 41 == 40) begin
          wr(8'hCC, 16'd1);
          rd(8'hCC, m_thrf, "R2 random locked write");
        end
        cyc(o, m, "R10 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule